// File: doc/BRIEF.md
# Lane Metaframe Framing Generator

This block sits between a per-lane transmit FIFO and the later lane stages (CRC insertion, scrambling, disparity inversion). It takes 64-bit words, each with a 1-bit control flag, and places them in a repeating metaframe. Every metaframe starts with three framing words: a lane-alignment word, a scrambler-state word and a clock-compensation skip word. Payload words follow, and a diagnostic word closes the metaframe. Each output is a 67-bit block. Bits [63:0] carry the content, bits [65:64] carry the sync header, and bit 66 is reserved for a later inversion stage.

The metaframe length is a quasi-static input. It counts every word in the metaframe, framing words included. The far end must be set to the same length. While a framing word goes out, the FIFO read enable is held low, so no payload word is dropped. A payload slot with no valid FIFO data produces an empty cycle and does not move the position. The diagnostic word's CRC field and the scrambler-state field are left at zero for later stages to overwrite.

Top module: `lane_frame_gen`

## Requirements
- R1: Within a metaframe of effective length L, the positions are emitted in this order: position 0 is the alignment word, position 1 is the scrambler-state word, position 2 is the skip word, positions 3 to L-2 are payload, and position L-1 is the diagnostic word. After position L-1 the sequence returns to position 0.
- R2: An `mf_len` value below 5 acts as 5, and a value above 8192 acts as 8192.
- R3: `rd_en` is high exactly when the next slot is a payload slot. When `rd_en` is low, a framing word is emitted on the next clock edge whatever `in_valid` is.
- R4: A word accepted while `rd_en` and `in_valid` are both high appears one cycle later with `out_valid` high and bits [63:0] equal to `in_data`. Its header in bits [65:64] is 2'b01 when `in_ctl` is 0 and 2'b10 when `in_ctl` is 1.
- R5: In a payload slot with `in_valid` low, `out_valid` is low on the next cycle and the metaframe position does not advance.
- R6: Every framing word has header 2'b10. Their bits [63:0] are as follows. The alignment word is 64'h78F6_78F6_78F6_78F6. The scrambler-state word is 6'h28 in bits [63:58] with zeros below. The skip word is 64'h1E1E_1E1E_1E1E_1E1E. The diagnostic word is 6'h19 in bits [63:58] with zeros below, so its CRC field in bits [31:0] is zero.
- R7: Bit 66 of every emitted word is 0.
- R8: While reset is held, `out_valid` is 0, `out_word` is 0 and `rd_en` is 0. The first word after reset is the alignment word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 64 | FIFO word |
| in_ctl | input | 1 | FIFO word is a burst/idle control word |
| in_valid | input | 1 | FIFO word present |
| mf_len | input | 14 | Metaframe length in words, framing words included |
| rd_en | output | 1 | FIFO read enable; a word is taken when high with `in_valid` |
| out_word | output | 67 | Framed block: [66] inversion placeholder, [65:64] header, [63:0] content |
| out_valid | output | 1 | `out_word` carries a new block |

## Verification
The stream is driven at several metaframe lengths, from the minimum (which has exactly one payload slot) up to the clamped maximum. This shows whether position counting and wrap-around follow the configured length. The valid patterns range from always present, through gappy masks, to never present. They separate a correct payload stall from a lost or duplicated word, and they show that framing words keep flowing while the FIFO is empty. Alternating control-flag masks show that the header follows the flag. Out-of-range lengths show the clamping.

// File: rtl/lane_frame_gen.sv
module lane_frame_gen #(
  parameter int          MIN_LEN  = 5,
  parameter int          MAX_LEN  = 8192,
  parameter int          LEN_W    = $clog2(MAX_LEN + 1),
  parameter logic [63:0] SYNC_PAT = 64'h78F6_78F6_78F6_78F6,
  parameter logic [63:0] SKIP_PAT = 64'h1E1E_1E1E_1E1E_1E1E,
  parameter logic [5:0]  SCR_TAG  = 6'h28,
  parameter logic [5:0]  DIAG_TAG = 6'h19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [63:0]      in_data,
  input  logic             in_ctl,
  input  logic             in_valid,
  input  logic [LEN_W-1:0] mf_len,
  output logic             rd_en,
  output logic [66:0]      out_word,
  output logic             out_valid
);

  localparam logic [1:0] HDR_CTL  = 2'b10;
  localparam logic [1:0] HDR_DATA = 2'b01;
  localparam logic [LEN_W-1:0] LEN_LO = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] LEN_HI = LEN_W'(MAX_LEN);

  typedef enum logic [2:0] {K_NONE, K_SYNC, K_SCR, K_SKIP, K_PAY, K_DIAG} kind_t;

  logic [LEN_W-1:0] len_eff, last, pos;
  kind_t            kind, kind_q;
  logic [66:0]      word_d;
  logic             fire;

  assign len_eff = (mf_len < LEN_LO) ? LEN_LO : (mf_len > LEN_HI) ? LEN_HI : mf_len;
  assign last    = len_eff - LEN_W'(1);

  always_comb begin
    if (pos == '0)                kind = K_SYNC;
    else if (pos == LEN_W'(1))    kind = K_SCR;
    else if (pos == LEN_W'(2))    kind = K_SKIP;
    else if (pos >= last)         kind = K_DIAG;
    else                          kind = K_PAY;
  end

  assign rd_en = (kind == K_PAY);
  assign fire  = !rd_en || in_valid;

  always_comb begin
    case (kind)
      K_SYNC:  word_d = {1'b0, HDR_CTL, SYNC_PAT};
      K_SCR:   word_d = {1'b0, HDR_CTL, SCR_TAG, 58'h0};
      K_SKIP:  word_d = {1'b0, HDR_CTL, SKIP_PAT};
      K_DIAG:  word_d = {1'b0, HDR_CTL, DIAG_TAG, 58'h0};
      default: word_d = {1'b0, in_ctl ? HDR_CTL : HDR_DATA, in_data};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos       <= '0;
      out_valid <= 1'b0;
      out_word  <= '0;
      kind_q    <= K_NONE;
    end else begin
      out_valid <= fire;
      kind_q    <= fire ? kind : K_NONE;
      if (fire) begin
        out_word <= word_d;
        pos      <= (pos >= last) ? '0 : pos + LEN_W'(1);
      end
    end
  end

  a_r1_diag_then_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_q == K_DIAG) |=> (kind_q == K_SYNC && out_word[63:0] == SYNC_PAT));

  a_r3_stall_emits_ctl: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (out_valid && out_word[65:64] == HDR_CTL));

  a_r4_data_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && in_valid) |=> (out_valid && out_word[63:0] == $past(in_data)));

  a_r5_gap_no_word: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !in_valid) |=> (!out_valid && $stable(pos)));

  a_r7_inv_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_word[66]);

endmodule

// File: tb/sim_lane_frame_gen.sv
module sim_lane_frame_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] in_data = '0;
  logic        in_ctl = 1'b0;
  logic        in_valid = 1'b0;
  logic [13:0] mf_len = 14'd5;
  logic        rd_en;
  logic [66:0] out_word;
  logic        out_valid;

  always #4 clk = ~clk;

  lane_frame_gen u0 (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_ctl(in_ctl),
    .in_valid(in_valid), .mf_len(mf_len), .rd_en(rd_en),
    .out_word(out_word), .out_valid(out_valid)
  );

  // {len[13:0], valid mask[7:0], ctl mask[7:0], cycles[15:0]}
  localparam logic [45:0] VEC [8] = '{
    {14'd5,    8'hFF, 8'h00, 16'd30},     // minimum length, one payload slot
    {14'd6,    8'hFF, 8'h55, 16'd40},
    {14'd8,    8'hA5, 8'h0F, 16'd60},
    {14'd12,   8'h33, 8'hF0, 16'd80},
    {14'd3,    8'hFF, 8'h00, 16'd30},     // R2 low clamp
    {14'd0,    8'h7F, 8'h01, 16'd30},     // R2 low clamp
    {14'd20,   8'h00, 8'h00, 16'd40},     // FIFO always empty
    {14'd9000, 8'hFF, 8'h00, 16'd16420}   // R2 high clamp
  };

  int          vecs = 0, bad = 0, np = 0, L = 5;
  logic        exp_v = 1'b0, have_exp = 1'b0;
  logic [66:0] exp_w = '0;

  function automatic logic [66:0] ctl_word(int p, int len);
    if (p == 0)             return {3'b010, 64'h78F6_78F6_78F6_78F6};
    else if (p == 1)        return {3'b010, 6'h28, 58'h0};
    else if (p == 2)        return {3'b010, 64'h1E1E_1E1E_1E1E_1E1E};
    else                    return {3'b010, 6'h19, 58'h0};
  endfunction

  task automatic check(bit ok, string req, logic [66:0] got, logic [66:0] want);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, want);
    end
  endtask

  task automatic drive(bit v, logic [63:0] d, bit c);
    bit ctrl;
    in_valid = v; in_data = d; in_ctl = c;
    #1;
    ctrl = (np < 3) || (np == L - 1);
    check(rd_en == !ctrl, "R3 rd_en", 67'(rd_en), 67'(!ctrl));
    if (ctrl || v) begin
      exp_v = 1'b1;
      exp_w = ctrl ? ctl_word(np, L) : {1'b0, c ? 2'b10 : 2'b01, d};
      np = (np == L - 1) ? 0 : np + 1;
    end else begin
      exp_v = 1'b0;
    end
    have_exp = 1'b1;
  endtask

  task automatic step(bit v, logic [63:0] d, bit c);
    @(negedge clk);
    if (have_exp) begin
      if (!exp_v)
        check(!out_valid, "R5 empty slot", 67'(out_valid), 67'(0));
      else begin
        check(out_valid, "R4 out_valid", 67'(out_valid), 67'(1));
        check(out_word[66] == 1'b0, "R7 bit66", out_word, exp_w);
        if (exp_w[65:64] == 2'b10 && exp_w[63:0] != d)
          check(out_word == exp_w, "R1/R6 framing word", out_word, exp_w);
        else
          check(out_word == exp_w, "R1/R4 payload word", out_word, exp_w);
      end
    end
    drive(v, d, c);
  endtask

  task automatic do_reset(logic [13:0] len);
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; mf_len = len;
    repeat (2) @(negedge clk);
    check(!out_valid, "R8 reset out_valid", 67'(out_valid), 67'(0));
    check(out_word == '0, "R8 reset out_word", out_word, 67'(0));
    check(!rd_en, "R8 reset rd_en", 67'(rd_en), 67'(0));
    rst_n = 1'b1;
    np = 0; have_exp = 1'b0;
    L = (len < 5) ? 5 : (len > 8192) ? 8192 : int'(len);
    drive(1'b1, 64'h0, 1'b0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin
      logic [13:0] len   = VEC[i][45:32];
      logic [7:0]  vmask = VEC[i][31:24];
      logic [7:0]  cmask = VEC[i][23:16];
      int          n     = int'(VEC[i][15:0]);
      do_reset(len);
      for (int k = 0; k < n; k++)
        step(vmask[k % 8], {8'(i), 24'h5A0000, 32'(k) * 32'h9E3779B1}, cmask[k % 8]);
      step(1'b0, 64'h0, 1'b0);
    end
    // R8: reset mid-metaframe restarts with the alignment word
    do_reset(14'd7);
    for (int k = 0; k < 4; k++) step(1'b1, 64'hABCD_0000_0000_0000 + 64'(k), 1'b0);
    do_reset(14'd7);
    step(1'b0, 64'h0, 1'b0);
    check(out_valid && out_word == {3'b010, 64'h78F6_78F6_78F6_78F6},
          "R8 first word after reset", out_word, {3'b010, 64'h78F6_78F6_78F6_78F6});
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL R1 watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

endmodule